// File: doc/BRIEF.md
# Lock-protected GPIO pad controller

This block controls one bank of general-purpose pads through a small register bus. A parameter sets the number of pads present (1 to 32). Each pad holds one output data bit and a two-bit drive mode built from a high mode bit and a low mode bit. Together they make the pad an input, a push-pull output, a sink-only pad (drives low, floats for a one) or a source-only pad (drives high, floats for a zero). Software moves data bits with write-one set and clear registers, and it may change them at any time.

The mode bits are guarded. A lock state machine has two states, `LK_FREE` and `LK_HELD`. The transition `KEY_GRAB` (from `LK_FREE` to `LK_HELD`) fires when the 16-bit key 0xD42F is written to the lock register. The transition `KEY_DROP` (from `LK_HELD` to `LK_FREE`) fires when 0x0000 is written to it. Every other lock write leaves the state as it is. Writes to the mode registers, direct or through their set and clear aliases, take effect only in `LK_HELD`. Direct writes let software restore a saved configuration after a power transition.

Pad inputs pass through a two-flop synchronizer before software reads them. All reads have one cycle of latency.

Top module: `gpio_lock_bank`

## Requirements
- R1: After reset, every pad has its output enable low, the lock reads as released, and both mode registers read as zero.
- R2: A write to offset 0x00 with bits 15:0 equal to 0xD42F sets lock bit 31. A write with bits 15:0 equal to 0x0000 clears it. Any other value leaves the lock unchanged. A read at 0x00 returns the lock flag in bit 31 and zeros elsewhere.
- R3: While the lock is released, writes to offsets 0x08, 0x0C, 0x50, 0x54 and 0x58 leave both mode registers unchanged.
- R4: While the lock is held, a write to 0x08 loads the high mode bits and a write to 0x0C loads the low mode bits. Both registers read back at the same offsets.
- R5: While the lock is held, each 1 bit written to 0x50 clears a high mode bit, to 0x54 sets a low mode bit, and to 0x58 clears a low mode bit. Bits written as 0 keep their value.
- R6: Each 1 bit written to 0x14 sets an output data bit, and each 1 bit written to 0x18 clears one. Bits written as 0 keep their value. These writes work whether the lock is held or not.
- R7: With {high,low} mode bits, 00 gives no drive. 01 drives the data bit. 10 drives 0 for data 0 and floats for data 1. 11 floats for data 0 and drives 1 for data 1. `pad_out` is 0 whenever `pad_oe` is 0.
- R8: A read at 0x04 returns the pad inputs after two synchronizer flops. A change on `pad_in` is not visible to a read sampled at the second clock edge after the change, and is visible to a read sampled at the third.
- R9: A read at any offset other than 0x00, 0x04, 0x08 or 0x0C returns zero, and a write to an unmapped offset changes no register.
- R10: Register bits at or above the configured pad count read as zero and cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe; data appears on `bus_rdata` the next cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| pad_in | input | NPADS | Asynchronous pad input levels |
| pad_oe | output | NPADS | Per-pad output enable |
| pad_out | output | NPADS | Per-pad driven value |

## Verification
The checker watches the following on every cycle:
- Mode registers stay frozen in any cycle that starts with the lock released.
- A key or release write always lands the lock state machine in `LK_HELD` or `LK_FREE` on the next cycle.
- No pad whose mode bits are both zero is ever driven.
- Reads of unmapped offsets return zero.

Only the bench's scenarios can show the rest:
- The full drive table against different data bits.
- Each alias acting on its own field.
- Masking above the pad count.
- The exact synchronizer latency.
- That stray key values and unmapped writes leave all state untouched.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

    localparam int OFS_W  = 8;
    localparam int WORD_W = 32;
    localparam int KEY_W  = 16;

    localparam logic [KEY_W-1:0] LOCK_KEY     = 16'hD42F;
    localparam logic [KEY_W-1:0] LOCK_RELEASE = 16'h0000;

    // Byte offsets; 0x00 holds the lock, the rest follow the decode map
    localparam logic [OFS_W-1:0] OFS_LOCK   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DIN    = 8'h04;
    localparam logic [OFS_W-1:0] OFS_MODE1  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_MODE0  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_DSET   = 8'h14;
    localparam logic [OFS_W-1:0] OFS_DCLR   = 8'h18;
    localparam logic [OFS_W-1:0] OFS_M1CLR  = 8'h50;
    localparam logic [OFS_W-1:0] OFS_M0SET  = 8'h54;
    localparam logic [OFS_W-1:0] OFS_M0CLR  = 8'h58;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        PM_INPUT    = 2'b00,
        PM_PUSHPULL = 2'b01,
        PM_SINK     = 2'b10,
        PM_SOURCE   = 2'b11
    } pad_mode_e;

endpackage

// File: rtl/gpio_lock_fsm.sv
module gpio_lock_fsm
    import gpio_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [KEY_W-1:0] key,
    output logic             lock_active
);

    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_FREE;
        else        state_q <= state_d;
    end

    // KEY_GRAB and KEY_DROP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE: if (lock_wr && key == LOCK_KEY)     state_d = LK_HELD;
            LK_HELD: if (lock_wr && key == LOCK_RELEASE) state_d = LK_FREE;
        endcase
    end

    always_comb begin
        lock_active = (state_q == LK_HELD);
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_lock_pkg::*;
#(
    parameter int NPADS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [NPADS-1:0] wbits,
    input  logic             lock_active,
    output logic [NPADS-1:0] mode0_q,
    output logic [NPADS-1:0] mode1_q,
    output logic [NPADS-1:0] data_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode0_q <= '0;
            mode1_q <= '0;
            data_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_DSET:  data_q <= data_q | wbits;
                OFS_DCLR:  data_q <= data_q & ~wbits;
                OFS_MODE1: if (lock_active) mode1_q <= wbits;
                OFS_MODE0: if (lock_active) mode0_q <= wbits;
                OFS_M1CLR: if (lock_active) mode1_q <= mode1_q & ~wbits;
                OFS_M0SET: if (lock_active) mode0_q <= mode0_q | wbits;
                OFS_M0CLR: if (lock_active) mode0_q <= mode0_q & ~wbits;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_lock_pkg::*;
#(
    parameter int NPADS = 6
) (
    input  logic [NPADS-1:0] mode0,
    input  logic [NPADS-1:0] mode1,
    input  logic [NPADS-1:0] data,
    output logic [NPADS-1:0] oe,
    output logic [NPADS-1:0] val
);

    for (genvar i = 0; i < NPADS; i++) begin : g_pad
        pad_mode_e m;
        logic      oe_i, val_i;
        assign m = pad_mode_e'({mode1[i], mode0[i]});

        always_comb begin
            unique case (m)
                PM_INPUT:    begin oe_i = 1'b0;     val_i = 1'b0;    end
                PM_PUSHPULL: begin oe_i = 1'b1;     val_i = data[i]; end
                PM_SINK:     begin oe_i = ~data[i]; val_i = 1'b0;    end
                PM_SOURCE:   begin oe_i = data[i];  val_i = data[i]; end
            endcase
        end

        assign oe[i]  = oe_i;
        assign val[i] = val_i;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
    import gpio_lock_pkg::*;
#(
    parameter int NPADS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NPADS-1:0]  pad_in,
    output logic [NPADS-1:0]  pad_oe,
    output logic [NPADS-1:0]  pad_out
);

    logic              lock_active;
    logic [NPADS-1:0]  mode0_q, mode1_q, data_q, din_sync;
    logic [WORD_W-1:0] rd_mux;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[WORD_W-1:KEY_W];

    function automatic logic [WORD_W-1:0] widen(input logic [NPADS-1:0] v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[NPADS-1:0] = v;
        return w;
    endfunction

    gpio_lock_fsm u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_wr     (bus_wr_en && bus_addr == OFS_LOCK),
        .key         (bus_wdata[KEY_W-1:0]),
        .lock_active (lock_active)
    );

    gpio_cfg_regs #(.NPADS(NPADS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr_en),
        .addr        (bus_addr),
        .wbits       (bus_wdata[NPADS-1:0]),
        .lock_active (lock_active),
        .mode0_q     (mode0_q),
        .mode1_q     (mode1_q),
        .data_q      (data_q)
    );

    gpio_pad_drive #(.NPADS(NPADS)) u_drive (
        .mode0 (mode0_q),
        .mode1 (mode1_q),
        .data  (data_q),
        .oe    (pad_oe),
        .val   (pad_out)
    );

    gpio_in_sync #(.W(NPADS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (din_sync)
    );

    always_comb begin
        case (bus_addr)
            OFS_LOCK:  rd_mux = {lock_active, {(WORD_W-1){1'b0}}};
            OFS_DIN:   rd_mux = widen(din_sync);
            OFS_MODE1: rd_mux = widen(mode1_q);
            OFS_MODE0: rd_mux = widen(mode0_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_lock_bank_chk.sv
module gpio_lock_bank_chk
    import gpio_lock_pkg::*;
#(
    parameter int NPADS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [OFS_W-1:0]  bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              lock_active,
    input logic [NPADS-1:0]  mode0_q,
    input logic [NPADS-1:0]  mode1_q,
    input logic [NPADS-1:0]  pad_oe
);

    logic readable, lock_wr, unused_hi;
    assign unused_hi = ^bus_wdata[WORD_W-1:KEY_W];
    assign readable  = (bus_addr == OFS_LOCK) || (bus_addr == OFS_DIN) ||
                       (bus_addr == OFS_MODE1) || (bus_addr == OFS_MODE0);
    assign lock_wr   = bus_wr_en && (bus_addr == OFS_LOCK);

    AST_MODE_FROZEN_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_active |=> $stable(mode0_q) && $stable(mode1_q)); // R3

    AST_KEY_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr && bus_wdata[KEY_W-1:0] == LOCK_KEY |=> lock_active); // R2

    AST_KEY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr && bus_wdata[KEY_W-1:0] == LOCK_RELEASE |=> !lock_active); // R2

    AST_INPUT_PAD_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~(mode0_q | mode1_q)) == '0); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en && !readable |=> bus_rdata == '0); // R9

endmodule

bind gpio_lock_bank gpio_lock_bank_chk #(.NPADS(NPADS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_en   (bus_wr_en),
    .bus_rd_en   (bus_rd_en),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .lock_active (lock_active),
    .mode0_q     (mode0_q),
    .mode1_q     (mode1_q),
    .pad_oe      (pad_oe)
);

// File: tb/gpio_lock_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_lock_bank_tb_top;

    localparam int NPADS = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic              bus_rd_en = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPADS-1:0]  pad_in = '0;
    logic [NPADS-1:0]  pad_oe, pad_out;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    gpio_lock_bank #(.NPADS(NPADS)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    // driver: queue the expected value, then issue the read
    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic check_pads(input logic [NPADS-1:0] e_oe, input logic [NPADS-1:0] e_out,
                              input string tag);
        n_checks++;
        if (pad_oe !== e_oe || pad_out !== e_out) begin
            n_fail++;
            $display("FAIL %s: oe=%h out=%h expected oe=%h out=%h", tag, pad_oe, pad_out, e_oe, e_out);
        end
    endtask

    // monitor: compare each read result one cycle after the strobe
    always @(posedge clk) rd_seen <= bus_rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: got %h expected no read", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_pads(6'h00, 6'h00, "R1 pads after reset");
        bus_read(8'h00, 32'h0, "R1 lock released");
        bus_read(8'h0C, 32'h0, "R1 low mode zero");
        bus_read(8'h08, 32'h0, "R1 high mode zero");

        // R3 mode writes blocked while free
        bus_write(8'h0C, 32'h3F);
        bus_write(8'h54, 32'h3F);
        bus_read(8'h0C, 32'h0, "R3 low mode untouched");
        check_pads(6'h00, 6'h00, "R3 pads still inputs");

        // R2 wrong key, then correct key
        bus_write(8'h00, 32'h1234);
        bus_read(8'h00, 32'h0, "R2 wrong key ignored");
        bus_write(8'h00, 32'hD42F);
        bus_read(8'h00, 32'h8000_0000, "R2 key grabs lock");

        // R4 direct loads, R10 masking above pad count
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, 32'h3F, "R4 R10 low mode load masked");
        bus_write(8'h08, 32'h0C);
        bus_read(8'h08, 32'h0C, "R4 high mode load");

        // R6 data set; R7 push-pull and source-only
        bus_write(8'h14, 32'h05);
        check_pads(6'h37, 6'h05, "R6 R7 push-pull and source");

        // R5 clear low mode bits of pads 2,3 -> sink-only
        bus_write(8'h58, 32'h0C);
        check_pads(6'h3B, 6'h01, "R5 R7 sink-only");
        bus_write(8'h50, 32'h04);
        bus_read(8'h08, 32'h08, "R5 high mode clear alias");
        bus_write(8'h54, 32'h00);
        bus_read(8'h0C, 32'h33, "R5 zero bits keep value");

        // R6 data clear
        bus_write(8'h18, 32'h01);
        check_pads(6'h3B, 6'h00, "R6 data clear");

        // R2 release; R3 blocked again; R6 still works unlocked
        bus_write(8'h00, 32'h0);
        bus_read(8'h00, 32'h0, "R2 release clears lock");
        bus_write(8'h0C, 32'h0);
        bus_write(8'h58, 32'h3F);
        bus_read(8'h0C, 32'h33, "R3 locked-out writes ignored");
        bus_write(8'h14, 32'h02);
        check_pads(6'h3B, 6'h02, "R6 data set while unlocked");

        // R8 two-flop input latency
        @(negedge clk);
        pad_in = 6'h2A;
        bus_read(8'h04, 32'h0, "R8 not yet visible");
        bus_read(8'h04, 32'h2A, "R8 synchronized input");

        // R9 unmapped reads and writes
        bus_read(8'h20, 32'h0, "R9 unmapped read zero");
        bus_read(8'h14, 32'h0, "R9 set alias reads zero");
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h0C, 32'h33, "R9 low mode unchanged");
        bus_read(8'h08, 32'h08, "R9 high mode unchanged");
        bus_read(8'h00, 32'h0, "R9 lock unchanged");
        check_pads(6'h3B, 6'h02, "R9 pads unchanged");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard drain: got %0d pending expected 0", exp_q.size());
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule